// File: doc/BRIEF.md
# Per-Processor Ordering Violation Queue

This block is a per-processor queue that holds tracking metadata for the processor's own loads and stores while they can still take part in a two-processor ordering cycle. Each entry holds an address, a local sequence number, and, for every processor in the system, a lower bound (the newest remote access allowed to sink a dependence into this entry) and an upper bound (the oldest remote access that this entry may still feed). Entries hold no data.

Accesses enter at the tail in program order and receive increasing sequence numbers. Once the surrounding logic declares the oldest access safe, that access leaves at the head. A snooped coherence request carries a remote processor ID, a remote sequence number and a role. The role says whether a remote access depends on a local one (producer side) or whether a local access consumed a remote one (consumer side). The request is matched by full address against the live entries. On a hit the block either flags an ordering violation or tightens the bounds: toward older entries for producer hits and toward younger entries for consumer hits. The same check serves read-after-write, write-after-write and write-after-read dependences. The hit entry's own sequence number always comes back in the response.

Top module: `scvq_top`

## Requirements
- R1: After reset the queue is empty, `full` is 0, `alloc_sn` shows 1, and `resp_valid` and `exc_valid` are 0.
- R2: An allocation while not full writes the tail slot and takes `alloc_sn` as its sequence number. The next `alloc_sn` is one higher, wrapping past 0 to 1. `full` is 1 when all DEPTH slots are live. An allocation while full is ignored, and `alloc_sn` stays unchanged.
- R3: `retire_valid` removes the head (oldest) entry. On an empty queue it has no effect, so the next allocation uses the same slot it would have used.
- R4: A snoop compares the full address against every live entry and picks the youngest match. One cycle later `resp_valid`=1, `resp_hit` is the match result, and `resp_sn` is that entry's sequence number (0 on a miss). A miss never raises an exception.
- R5: On a producer snoop (`snoop_kind`=0) that hits, an exception is raised if the remote sequence number is less than or equal to the entry's upper-side bound for that processor.
- R6: If the producer snoop raises no exception, the lower-side bound for that processor becomes min(bound, remote SN) on the hit entry and on every older live entry. Younger entries are untouched.
- R7: On a consumer snoop (`snoop_kind`=1) that hits, an exception is raised if the remote sequence number is greater than or equal to the entry's lower-side bound for that processor.
- R8: If the consumer snoop raises no exception, the upper-side bound for that processor becomes max(bound, remote SN) on the hit entry and on every younger live entry. Older entries are untouched.
- R9: An exception asserts `exc_valid` together with the response and reports the hit slot in `exc_idx` and the remote processor in `exc_pid`. It still returns the entry's sequence number and leaves all bounds unchanged.
- R10: A newly allocated entry starts with every lower-side bound at the all-ones maximum and every upper-side bound at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_valid | input | 1 | Record a new local access |
| alloc_addr | input | AW | Address of the new access |
| alloc_sn | output | SNW | Sequence number the next allocation receives |
| full | output | 1 | All slots live |
| retire_valid | input | 1 | Oldest access has become safe |
| snoop_valid | input | 1 | Snooped coherence request present |
| snoop_kind | input | 1 | 0 producer side, 1 consumer side |
| snoop_addr | input | AW | Snooped address |
| snoop_pid | input | PIDW | Remote processor ID |
| snoop_sn | input | SNW | Remote sequence number |
| resp_valid | output | 1 | Response for the snoop of the previous cycle |
| resp_hit | output | 1 | Snoop matched a live entry |
| resp_sn | output | SNW | Sequence number of the matched entry |
| exc_valid | output | 1 | Ordering violation detected |
| exc_idx | output | IW | Slot of the violating entry |
| exc_pid | output | PIDW | Remote processor of the violation |

## Verification
A bound that is lost or over-propagated inside the queue stays invisible until a later snoop on another entry tests it. At that point it shows as a missing or spurious `exc_valid` one cycle after that snoop. The bench therefore pairs every bound update with a follow-up snoop on an older and a younger entry, so that the direction of propagation can be seen. Head and tail pointer errors show up as a wrong `exc_idx` or `resp_sn` on the first hit after the error, and sequence counter errors show up at once on `alloc_sn`.

// File: rtl/scvq_pkg.sv
package scvq_pkg;
  typedef enum logic {
    SNP_PROD = 1'b0,
    SNP_CONS = 1'b1
  } snp_kind_e;
endpackage

// File: rtl/scvq_lookup.sv
module scvq_lookup #(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  input  logic [IW-1:0]            head,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx,
  output logic [DEPTH-1:0]         older_m,
  output logic [DEPTH-1:0]         younger_m
);
  logic [DEPTH-1:0]         match;
  logic [DEPTH-1:0][IW-1:0] age;
  logic [IW-1:0]            best_age;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (addr[i] == key);
    assign age[i]   = IW'(i) - head;
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit || age[i] > best_age)) begin
        hit      = 1'b1;
        hit_idx  = IW'(i);
        best_age = age[i];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    assign older_m[i]   = vld[i] && (age[i] <= best_age);
    assign younger_m[i] = vld[i] && (age[i] >= best_age);
  end
endmodule

// File: rtl/scvq_bounds.sv
module scvq_bounds #(
  parameter int NPROC = 8,
  parameter int SNW   = 8,
  localparam int PIDW = $clog2(NPROC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       prod_upd,
  input  logic                       cons_upd,
  input  logic [PIDW-1:0]            pid,
  input  logic [SNW-1:0]             sn,
  output logic [NPROC-1:0][SNW-1:0]  src_bnd,
  output logic [NPROC-1:0][SNW-1:0]  dst_bnd
);
  logic [NPROC-1:0][SNW-1:0] src_q, src_d;
  logic [NPROC-1:0][SNW-1:0] dst_q, dst_d;
  logic                      en;

  assign en = load || prod_upd || cons_upd;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    if (load) begin
      for (int p = 0; p < NPROC; p++) begin
        src_d[p] = '1;
        dst_d[p] = '0;
      end
    end else begin
      if (prod_upd && (sn < src_q[pid])) src_d[pid] = sn;
      if (cons_upd && (sn > dst_q[pid])) dst_d[pid] = sn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '1;
      dst_q <= '0;
    end else if (en) begin
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  assign src_bnd = src_q;
  assign dst_bnd = dst_q;

  for (genvar p = 0; p < NPROC; p++) begin : g_chk
    // R6: lower-side bound only moves down between allocations
    a_r6_src_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (src_q[p] <= $past(src_q[p])));
    // R8: upper-side bound only moves up between allocations
    a_r8_dst_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (dst_q[p] >= $past(dst_q[p])));
    // R10: allocation resets both bounds
    a_r10_load_reset: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (src_q[p] == '1) && (dst_q[p] == '0));
  end
endmodule

// File: rtl/scvq_top.sv
module scvq_top
  import scvq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NPROC = 8,
  parameter int AW    = 16,
  parameter int SNW   = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int PIDW = $clog2(NPROC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [AW-1:0]   alloc_addr,
  output logic [SNW-1:0]  alloc_sn,
  output logic            full,
  input  logic            retire_valid,
  input  logic            snoop_valid,
  input  logic            snoop_kind,
  input  logic [AW-1:0]   snoop_addr,
  input  logic [PIDW-1:0] snoop_pid,
  input  logic [SNW-1:0]  snoop_sn,
  output logic            resp_valid,
  output logic            resp_hit,
  output logic [SNW-1:0]  resp_sn,
  output logic            exc_valid,
  output logic [IW-1:0]   exc_idx,
  output logic [PIDW-1:0] exc_pid
);
  localparam int CW = IW + 1;

  // queue control state
  logic [IW-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [SNW-1:0] nsn_q, nsn_d;
  logic           do_alloc, do_ret, ctl_en;

  // entry storage
  logic [DEPTH-1:0]           vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0]   addr_q;
  logic [DEPTH-1:0][SNW-1:0]  sn_q;
  logic [DEPTH-1:0]           load_v;

  // bounds of all entries
  logic [DEPTH-1:0][NPROC-1:0][SNW-1:0] src_all, dst_all;

  // lookup
  logic             hit;
  logic [IW-1:0]    hit_idx;
  logic [DEPTH-1:0] older_m, younger_m;
  logic [SNW-1:0]   sel_src, sel_dst;
  logic             is_prod, is_cons, prod_exc, cons_exc, any_exc;
  logic [DEPTH-1:0] prod_upd_v, cons_upd_v;

  // response state
  logic            rv_q, rh_q, ex_q;
  logic [SNW-1:0]  rsn_q, rsn_d;
  logic [IW-1:0]   eidx_q;
  logic [PIDW-1:0] epid_q;

  assign full     = (cnt_q == CW'(DEPTH));
  assign do_alloc = alloc_valid && !full;
  assign do_ret   = retire_valid && (cnt_q != '0);
  assign ctl_en   = do_alloc || do_ret;
  assign alloc_sn = nsn_q;

  // ---------------- next-state for queue control ----------------
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    nsn_d  = nsn_q;
    vld_d  = vld_q;
    if (do_ret) begin
      vld_d[head_q] = 1'b0;
      head_d        = head_q + 1'b1;
    end
    if (do_alloc) begin
      vld_d[tail_q] = 1'b1;
      tail_d        = tail_q + 1'b1;
      nsn_d         = (nsn_q == '1) ? SNW'(1) : nsn_q + 1'b1;
    end
    case ({do_alloc, do_ret})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      nsn_q  <= SNW'(1);
      vld_q  <= '0;
    end else if (ctl_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      nsn_q  <= nsn_d;
      vld_q  <= vld_d;
    end
  end

  // ---------------- per-entry storage ----------------
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign load_v[i] = do_alloc && (tail_q == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        sn_q[i]   <= '0;
      end else if (load_v[i]) begin
        addr_q[i] <= alloc_addr;
        sn_q[i]   <= nsn_q;
      end
    end

    assign prod_upd_v[i] = is_prod && hit && !prod_exc && older_m[i];
    assign cons_upd_v[i] = is_cons && hit && !cons_exc && younger_m[i];

    scvq_bounds #(.NPROC(NPROC), .SNW(SNW)) u_bnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_v[i]),
      .prod_upd (prod_upd_v[i]),
      .cons_upd (cons_upd_v[i]),
      .pid      (snoop_pid),
      .sn       (snoop_sn),
      .src_bnd  (src_all[i]),
      .dst_bnd  (dst_all[i])
    );
  end

  // ---------------- snoop lookup and check ----------------
  scvq_lookup #(.DEPTH(DEPTH), .AW(AW)) u_look (
    .vld       (vld_q),
    .addr      (addr_q),
    .head      (head_q),
    .key       (snoop_addr),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .older_m   (older_m),
    .younger_m (younger_m)
  );

  assign is_prod  = snoop_valid && (snp_kind_e'(snoop_kind) == SNP_PROD);
  assign is_cons  = snoop_valid && (snp_kind_e'(snoop_kind) == SNP_CONS);
  assign sel_src  = src_all[hit_idx][snoop_pid];
  assign sel_dst  = dst_all[hit_idx][snoop_pid];
  assign prod_exc = is_prod && hit && (snoop_sn <= sel_dst);
  assign cons_exc = is_cons && hit && (snoop_sn >= sel_src);
  assign any_exc  = prod_exc || cons_exc;
  assign rsn_d    = hit ? sn_q[hit_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      ex_q <= 1'b0;
    end else begin
      rv_q <= snoop_valid;
      rh_q <= snoop_valid && hit;
      ex_q <= any_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsn_q  <= '0;
      eidx_q <= '0;
      epid_q <= '0;
    end else if (snoop_valid) begin
      rsn_q  <= rsn_d;
      eidx_q <= hit_idx;
      epid_q <= snoop_pid;
    end
  end

  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_sn    = rsn_q;
  assign exc_valid  = ex_q;
  assign exc_idx    = eidx_q;
  assign exc_pid    = epid_q;

  // ---------------- assertions ----------------
  // R2: occupancy never exceeds the depth
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R2: allocation while full leaves occupancy and sequence counter alone
  a_r2_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !retire_valid) |=> ($stable(cnt_q) && $stable(alloc_sn)));
  // R3: retire on empty queue does nothing
  a_r3_empty_retire: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && retire_valid && !alloc_valid) |=> (cnt_q == '0));
  // R4: every snoop gets a response one cycle later
  a_r4_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |=> resp_valid);
  // R4/R9: an exception only accompanies a hit response
  a_r9_exc_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (resp_valid && resp_hit));
endmodule

// File: tb/scvq_top_tb.sv
module scvq_top_tb;
  localparam int DEPTH = 16;
  localparam int NPROC = 8;
  localparam int AW    = 16;
  localparam int SNW   = 8;
  localparam int IW    = 4;
  localparam int PIDW  = 3;

  // vector: op(2) addr(16) pid(3) sn(8) ehit(1) eexc(1) esn(8) eidx(4) req(4)
  // op: 0 alloc, 1 retire, 2 producer snoop, 3 consumer snoop
  localparam int VW = 47;
  localparam int NV = 18;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 16'h0010, 3'd0, 8'd0,   1'b0, 1'b0, 8'd1, 4'd0, 4'd2},  // R2 slot0 sn1
    {2'd0, 16'h0020, 3'd0, 8'd0,   1'b0, 1'b0, 8'd2, 4'd1, 4'd2},  // R2 slot1 sn2
    {2'd0, 16'h0030, 3'd0, 8'd0,   1'b0, 1'b0, 8'd3, 4'd2, 4'd2},  // R2 slot2 sn3
    {2'd0, 16'h0020, 3'd0, 8'd0,   1'b0, 1'b0, 8'd4, 4'd3, 4'd2},  // R2 slot3 sn4 same addr
    {2'd2, 16'h0020, 3'd2, 8'd7,   1'b1, 1'b0, 8'd4, 4'd3, 4'd4},  // R4 youngest hit, R6 src[2]=7 on 0..3
    {2'd3, 16'h0010, 3'd2, 8'd7,   1'b1, 1'b1, 8'd1, 4'd0, 4'd7},  // R7 7>=7 on older entry
    {2'd3, 16'h0010, 3'd2, 8'd6,   1'b1, 1'b0, 8'd1, 4'd0, 4'd8},  // R8 dst[2]=6 on 0..3
    {2'd2, 16'h0030, 3'd2, 8'd6,   1'b1, 1'b1, 8'd3, 4'd2, 4'd5},  // R5 6<=6
    {2'd2, 16'h0030, 3'd2, 8'd8,   1'b1, 1'b0, 8'd3, 4'd2, 4'd6},  // R6 pass
    {2'd3, 16'h0040, 3'd1, 8'd3,   1'b0, 1'b0, 8'd0, 4'd0, 4'd4},  // R4 miss
    {2'd3, 16'h0030, 3'd1, 8'd200, 1'b1, 1'b0, 8'd3, 4'd2, 4'd8},  // R8 dst[1]=200 on 2,3
    {2'd2, 16'h0010, 3'd1, 8'd100, 1'b1, 1'b0, 8'd1, 4'd0, 4'd8},  // R8 older entry untouched
    {2'd2, 16'h0020, 3'd1, 8'd150, 1'b1, 1'b1, 8'd4, 4'd3, 4'd9},  // R9 younger got 200
    {2'd1, 16'h0000, 3'd0, 8'd0,   1'b0, 1'b0, 8'd0, 4'd0, 4'd3},  // R3 drop slot0
    {2'd2, 16'h0010, 3'd3, 8'd5,   1'b0, 1'b0, 8'd0, 4'd0, 4'd3},  // R3 retired entry gone
    {2'd0, 16'h0050, 3'd0, 8'd0,   1'b0, 1'b0, 8'd5, 4'd4, 4'd2},  // R2 slot4 sn5
    {2'd3, 16'h0050, 3'd2, 8'd8,   1'b1, 1'b0, 8'd5, 4'd4, 4'd10}, // R10 fresh src max
    {2'd2, 16'h0050, 3'd2, 8'd7,   1'b1, 1'b1, 8'd5, 4'd4, 4'd5}   // R5 dst[2]=8 now
  };

  logic            clk;
  logic            rst_n;
  logic            alloc_valid;
  logic [AW-1:0]   alloc_addr;
  logic [SNW-1:0]  alloc_sn;
  logic            full;
  logic            retire_valid;
  logic            snoop_valid;
  logic            snoop_kind;
  logic [AW-1:0]   snoop_addr;
  logic [PIDW-1:0] snoop_pid;
  logic [SNW-1:0]  snoop_sn;
  logic            resp_valid;
  logic            resp_hit;
  logic [SNW-1:0]  resp_sn;
  logic            exc_valid;
  logic [IW-1:0]   exc_idx;
  logic [PIDW-1:0] exc_pid;

  int checks;
  int fails;
  bit done;

  scvq_top #(.DEPTH(DEPTH), .NPROC(NPROC), .AW(AW), .SNW(SNW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_addr   (alloc_addr),
    .alloc_sn     (alloc_sn),
    .full         (full),
    .retire_valid (retire_valid),
    .snoop_valid  (snoop_valid),
    .snoop_kind   (snoop_kind),
    .snoop_addr   (snoop_addr),
    .snoop_pid    (snoop_pid),
    .snoop_sn     (snoop_sn),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_sn      (resp_sn),
    .exc_valid    (exc_valid),
    .exc_idx      (exc_idx),
    .exc_pid      (exc_pid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation; returns alloc_sn seen before the edge
  task automatic op(input logic [1:0] kind, input logic [AW-1:0] a,
                    input logic [PIDW-1:0] p, input logic [SNW-1:0] s,
                    output logic [SNW-1:0] sn_pre);
    @(negedge clk);
    alloc_valid  = (kind == 2'd0);
    retire_valid = (kind == 2'd1);
    snoop_valid  = kind[1];
    snoop_kind   = kind[0];
    alloc_addr   = a;
    snoop_addr   = a;
    snoop_pid    = p;
    snoop_sn     = s;
    #1 sn_pre = alloc_sn;
    @(negedge clk);
    alloc_valid  = 1'b0;
    retire_valid = 1'b0;
    snoop_valid  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [SNW-1:0] pre;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    alloc_valid = 1'b0; retire_valid = 1'b0; snoop_valid = 1'b0;
    snoop_kind = 1'b0; alloc_addr = '0; snoop_addr = '0; snoop_pid = '0; snoop_sn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 full", 32'(full), 0);
    chk("R1 alloc_sn", 32'(alloc_sn), 1);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 exc_valid", 32'(exc_valid), 0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[3:0], k);
      op(v[46:45], v[44:29], v[28:26], v[25:18], pre);
      if (v[46:45] == 2'd0) begin
        chk(tag, 32'(pre), 32'(v[15:8]));
      end else if (v[46]) begin
        chk(tag, 32'(resp_valid), 1);
        chk(tag, 32'(resp_hit), 32'(v[17]));
        chk(tag, 32'(resp_sn), 32'(v[15:8]));
        chk(tag, 32'(exc_valid), 32'(v[16]));
        if (v[16]) begin
          chk(tag, 32'(exc_idx), 32'(v[7:4]));
          chk(tag, 32'(exc_pid), 32'(v[28:26]));
        end
      end else begin
        chk(tag, 32'(resp_valid), 0);
      end
    end

    // R2 fill the remaining 12 slots: sn 6..17
    for (int k = 0; k < 12; k++) begin
      op(2'd0, 16'h0100 + 16'(k), 3'd0, 8'd0, pre);
      chk("R2 fill sn", 32'(pre), 32'(6 + k));
    end
    chk("R2 full set", 32'(full), 1);
    op(2'd0, 16'h0200, 3'd0, 8'd0, pre);
    chk("R2 alloc when full ignored", 32'(alloc_sn), 18);
    chk("R2 still full", 32'(full), 1);

    // R3 drain all 16 entries, then one extra retire on empty
    for (int k = 0; k < 16; k++) op(2'd1, '0, 3'd0, 8'd0, pre);
    chk("R3 drained", 32'(full), 0);
    op(2'd1, '0, 3'd0, 8'd0, pre);
    op(2'd0, 16'h0077, 3'd0, 8'd0, pre);
    chk("R2 sn after full", 32'(pre), 18);
    // R10 fresh upper bound 0, so remote sn 0 violates; slot shows R3 head unmoved
    op(2'd2, 16'h0077, 3'd0, 8'd0, pre);
    chk("R10 exc on fresh entry", 32'(exc_valid), 1);
    chk("R3 slot after empty retire", 32'(exc_idx), 1);
    chk("R9 resp_sn on exc", 32'(resp_sn), 18);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule